// File: doc/BRIEF.md
# Compare Match Output Pin Unit

This block keeps the one-bit output-compare level for a single timer channel and decides what a shared general-purpose port pin drives. Strobes from the timer tell it when a compare match has occurred, when the counter has reached its bottom value (PWM operation only), or when software forces a compare. A two-bit mode field and a PWM-class select choose which action is applied to the stored level.

Whenever the mode field is nonzero, the stored level replaces the port's own data bit as the pin value. The pin direction always comes from the port's direction bit. Software can therefore load a known level into the stored bit while the pin is still an input, then turn the pin into an output and see that level at once. The counter, the comparator, the duty-cycle logic and any input capture path belong to other blocks.

Top module: `cmp_out_unit`

## Requirements
- R1: A synchronous active-high reset clears the stored compare level to 0.
- R2: With mode field 00 the pin value equals `port_data_i`, and no strobe changes the stored level.
- R3: With a nonzero mode field the pin value equals the stored level, combinationally.
- R4: `pin_oe_o` always equals `port_dir_i`, whatever the mode or strobes.
- R5: With `pwm_sel_i` = 0, a match applies an action on the rising edge where it is sampled high: mode 01 toggles, 10 clears, 11 sets. The new level is visible from the next cycle.
- R6: With `pwm_sel_i` = 0, `force_i` applies the same action as a match. A match and a force in the same cycle apply the action only once, so mode 01 toggles once.
- R7: With `pwm_sel_i` = 1, `force_i` has no effect on the stored level.
- R8: With `pwm_sel_i` = 1, mode 10 clears the level on a match and sets it on a bottom strobe. Mode 11 sets it on a match and clears it on a bottom strobe.
- R9: With `pwm_sel_i` = 1 and mode 01, no strobe changes the level. With `pwm_sel_i` = 0, the bottom strobe is ignored.
- R10: With `pwm_sel_i` = 1, a match and a bottom strobe in the same cycle apply only the match action.
- R11: The level can be loaded through a force while `port_dir_i` = 0. Raising `port_dir_i` then shows that level on the pin in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| match_i | input | 1 | Compare match strobe |
| bottom_i | input | 1 | Counter-at-bottom strobe (PWM class only) |
| force_i | input | 1 | Software force-compare strobe |
| cmp_mode_i | input | 2 | Compare output mode field |
| pwm_sel_i | input | 1 | 1 = PWM class, 0 = non-PWM class |
| port_data_i | input | 1 | General port data bit |
| port_dir_i | input | 1 | General port direction bit, 1 = output |
| pin_out_o | output | 1 | Value driven toward the pin |
| pin_oe_o | output | 1 | Pin output enable |

## Verification
The bench targets the case where a match and a force arrive together in toggle mode. A design that counted both strobes would toggle twice and leave the level unchanged. It also drives a force during PWM operation and a bottom strobe during non-PWM operation; a design that leaked either one would flip the stored level. A simultaneous match and bottom strobe under PWM checks that the match wins. A direction change straight after a preload checks that the pin follows the stored level in the same cycle, not one cycle late. Mode 00 with active strobes checks that the pin tracks the port bit and that the hidden level does not move.

// File: rtl/cmp_out_pkg.sv
package cmp_out_pkg;

    localparam int MODE_W = 2;

    // Mode field encoding; names follow the non-PWM meaning
    typedef enum logic [MODE_W-1:0] {
        MD_OFF = 2'b00,
        MD_TGL = 2'b01,
        MD_CLR = 2'b10,
        MD_SET = 2'b11
    } cmp_mode_e;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_TOGGLE = 2'd1,
        ACT_CLEAR  = 2'd2,
        ACT_SET    = 2'd3
    } cmp_act_e;

    typedef struct packed {
        logic match;
        logic bottom;
        logic frc;
        logic pwm;
    } cmp_strobe_t;

    function automatic cmp_act_e nonpwm_action(input cmp_mode_e m);
        case (m)
            MD_TGL:  return ACT_TOGGLE;
            MD_CLR:  return ACT_CLEAR;
            MD_SET:  return ACT_SET;
            default: return ACT_HOLD;
        endcase
    endfunction

    // at_match = 1 for the match event, 0 for the bottom event
    function automatic cmp_act_e pwm_action(input cmp_mode_e m, input logic at_match);
        case (m)
            MD_CLR:  return at_match ? ACT_CLEAR : ACT_SET;
            MD_SET:  return at_match ? ACT_SET : ACT_CLEAR;
            default: return ACT_HOLD;
        endcase
    endfunction

    function automatic logic apply_action(input cmp_act_e a, input logic q);
        case (a)
            ACT_TOGGLE: return ~q;
            ACT_CLEAR:  return 1'b0;
            ACT_SET:    return 1'b1;
            default:    return q;
        endcase
    endfunction

endpackage

// File: rtl/cmp_action_dec.sv
module cmp_action_dec
    import cmp_out_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  cmp_strobe_t stb,
    input  cmp_mode_e   mode,
    output cmp_act_e    act
);

    logic nonpwm_evt;

    assign nonpwm_evt = stb.match | stb.frc;

    always_comb begin
        act = ACT_HOLD;
        if (!stb.pwm) begin
            if (nonpwm_evt) begin
                act = nonpwm_action(mode);
            end
        end else if (stb.match) begin
            act = pwm_action(mode, 1'b1);
        end else if (stb.bottom) begin
            act = pwm_action(mode, 1'b0);
        end
    end

    // R7
    force_ignored_pwm_chk: assert property (@(posedge clk) disable iff (rst)
        (stb.pwm && stb.frc && !stb.match && !stb.bottom) |-> (act == ACT_HOLD));

    // R9
    bottom_ignored_nonpwm_chk: assert property (@(posedge clk) disable iff (rst)
        (!stb.pwm && stb.bottom && !stb.match && !stb.frc) |-> (act == ACT_HOLD));

endmodule

// File: rtl/cmp_state_reg.sv
module cmp_state_reg
    import cmp_out_pkg::*;
#(
    parameter logic RESET_LEVEL = 1'b0
) (
    input  logic     clk,
    input  logic     rst,
    input  cmp_act_e act,
    output logic     q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RESET_LEVEL;
        end else begin
            q <= apply_action(act, q);
        end
    end

    // R2
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_HOLD) |=> $stable(q));

    // R5
    toggle_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_TOGGLE) |=> (q != $past(q)));

endmodule

// File: rtl/cmp_pin_mux.sv
module cmp_pin_mux
    import cmp_out_pkg::*;
(
    input  cmp_mode_e mode,
    input  logic      state,
    input  logic      port_data,
    input  logic      port_dir,
    output logic      pin_out,
    output logic      pin_oe
);

    logic override_on;

    assign override_on = (mode != MD_OFF);

    always_comb begin
        pin_out = override_on ? state : port_data;
        pin_oe  = port_dir;
    end

endmodule

// File: rtl/cmp_out_unit.sv
module cmp_out_unit
    import cmp_out_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              match_i,
    input  logic              bottom_i,
    input  logic              force_i,
    input  logic [MODE_W-1:0] cmp_mode_i,
    input  logic              pwm_sel_i,
    input  logic              port_data_i,
    input  logic              port_dir_i,
    output logic              pin_out_o,
    output logic              pin_oe_o
);

    cmp_strobe_t stb;
    cmp_mode_e   mode;
    cmp_act_e    act;
    logic        state_q;

    assign stb  = '{match: match_i, bottom: bottom_i, frc: force_i, pwm: pwm_sel_i};
    assign mode = cmp_mode_e'(cmp_mode_i);

    cmp_action_dec u_dec (
        .clk  (clk),
        .rst  (rst),
        .stb  (stb),
        .mode (mode),
        .act  (act)
    );

    cmp_state_reg #(.RESET_LEVEL(1'b0)) u_state (
        .clk (clk),
        .rst (rst),
        .act (act),
        .q   (state_q)
    );

    cmp_pin_mux u_mux (
        .mode      (mode),
        .state     (state_q),
        .port_data (port_data_i),
        .port_dir  (port_dir_i),
        .pin_out   (pin_out_o),
        .pin_oe    (pin_oe_o)
    );

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> !state_q);

    // R8
    pwm_clr_match_chk: assert property (@(posedge clk) disable iff (rst)
        (pwm_sel_i && match_i && cmp_mode_i == 2'b10) |=> !state_q);

    // R10
    pwm_match_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (pwm_sel_i && match_i && bottom_i && cmp_mode_i == 2'b11) |=> state_q);

endmodule

// File: tb/cmp_out_unit_tb.sv
module cmp_out_unit_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       match_i, bottom_i, force_i, pwm_sel_i, port_data_i, port_dir_i;
    logic [1:0] cmp_mode_i;
    logic       pin_out_o, pin_oe_o;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;
    logic model_q;

    always #10 clk = ~clk;

    cmp_out_unit u_dut (
        .clk         (clk),
        .rst         (rst),
        .match_i     (match_i),
        .bottom_i    (bottom_i),
        .force_i     (force_i),
        .cmp_mode_i  (cmp_mode_i),
        .pwm_sel_i   (pwm_sel_i),
        .port_data_i (port_data_i),
        .port_dir_i  (port_dir_i),
        .pin_out_o   (pin_out_o),
        .pin_oe_o    (pin_oe_o)
    );

    function automatic logic expected_next(input logic q, input logic m, input logic b,
                                           input logic f, input logic [1:0] md, input logic pwm);
        if (!pwm) begin
            if (m || f) begin
                case (md)
                    2'b01:   return ~q;
                    2'b10:   return 1'b0;
                    2'b11:   return 1'b1;
                    default: return q;
                endcase
            end
            return q;
        end
        if (m) begin
            if (md == 2'b10) return 1'b0;
            if (md == 2'b11) return 1'b1;
            return q;
        end
        if (b) begin
            if (md == 2'b10) return 1'b1;
            if (md == 2'b11) return 1'b0;
        end
        return q;
    endfunction

    task automatic check(input string tag, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    // Drive one cycle of inputs, check the outputs before the edge, then advance the model.
    task automatic step(input logic m, input logic b, input logic f, input logic [1:0] md,
                        input logic pwm, input logic pd, input logic dir, input string tag);
        string t;
        @(negedge clk);
        match_i = m; bottom_i = b; force_i = f; cmp_mode_i = md;
        pwm_sel_i = pwm; port_data_i = pd; port_dir_i = dir;
        #1;
        if (tag != "") t = tag;
        else if (md == 2'b00) t = "R2";
        else t = "R3";
        check(t, pin_out_o, (md != 2'b00) ? model_q : pd);
        check("R4", pin_oe_o, dir);
        model_q = expected_next(model_q, m, b, f, md, pwm);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        r = $urandom(32'h5EED_0042);
        rst = 1'b1;
        match_i = 0; bottom_i = 0; force_i = 0; cmp_mode_i = 2'b00;
        pwm_sel_i = 0; port_data_i = 0; port_dir_i = 0;
        model_q = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: level is 0 after reset
        step(0,0,0,2'b11,0,1,1,"R1");

        // R5: non-PWM set, clear, toggle
        step(1,0,0,2'b11,0,0,1,"");
        step(1,0,0,2'b10,0,0,1,"R5");
        step(1,0,0,2'b01,0,0,1,"R5");
        step(0,0,0,2'b01,0,0,1,"R5");

        // R6: force acts like a match; both together toggle once
        step(0,0,1,2'b01,0,0,1,"");
        step(1,0,1,2'b01,0,0,1,"R6");
        step(0,0,0,2'b01,0,0,1,"R6");

        // R7: force ignored under PWM (level is 1 here)
        step(0,0,1,2'b10,1,0,1,"");
        step(0,0,0,2'b10,1,0,1,"R7");

        // R8: PWM match/bottom actions
        step(1,0,0,2'b10,1,0,1,"");
        step(0,1,0,2'b10,1,0,1,"R8");
        step(0,1,0,2'b11,1,0,1,"R8");
        step(1,0,0,2'b11,1,0,1,"R8");
        step(0,0,0,2'b11,1,0,1,"R8");

        // R9: PWM mode 01 inert; bottom inert outside PWM
        step(1,1,1,2'b01,1,0,1,"");
        step(0,1,0,2'b10,0,0,1,"R9");
        step(0,0,0,2'b10,0,0,1,"R9");

        // R10: match beats bottom under PWM (level 1 now, mode 10 match clears)
        step(1,1,0,2'b10,1,0,1,"");
        step(0,0,0,2'b10,1,0,1,"R10");

        // R2: mode 00 shows port bit, strobes do not move the level (level 0)
        step(1,0,1,2'b00,0,1,1,"R2");
        step(1,1,1,2'b00,1,0,1,"R2");
        step(0,0,0,2'b11,0,1,1,"R2");

        // R11: preload while pin is input, then enable output
        step(0,0,1,2'b11,0,0,0,"");
        step(0,0,0,2'b11,0,0,1,"R11");

        // Constrained random mix
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] v;
            v = $urandom;
            step(v[0] & v[8], v[1] & v[9], v[2] & v[10], v[4:3], v[5], v[6], v[7], "");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule